// File: doc/BRIEF.md
# GF(2) Outer-Product Matrix Multiplier

This block is a coprocessor that multiplies two square bit matrices over GF(2) (AND for multiply, XOR for add). A host issues one-cycle commands through a custom-instruction style port. Each command carries a 32-bit data word and an 8-bit code that selects one of four operations: load a row of A, load a row of B, read a row of the product, or clear the product.

The rows of A are stored in a transpose register array. Each time a row of B arrives, the array supplies one column of A. The product is then updated with one rank-one outer product of that column and that B row, in the same clock. After each B row the array rotates every stored row circularly by one position. After a full group of B rows the array is back in its loaded arrangement, so the same A can multiply further B matrices without being reloaded. The product register is cleared only by reset or by the clear command. Successive products therefore add up (XOR) unless the host clears between them.

The port is a plain start/done handshake with no back-pressure. A command is taken in any cycle where `cmd_start` and `clk_en` are both high. Each command finishes in a single cycle, and `cmd_done` pulses in the following cycle. The host may issue a new command every cycle.

Top module: `gf2_outer_mm`

## Requirements
- R1: After reset, `cmd_done` is low, `rsp_data` is zero and every product row reads as zero.
- R2: A command is accepted only in a cycle where both `cmd_start` and `clk_en` are high. `cmd_done` is high for exactly one cycle after each accepted command and is low otherwise. A command presented while `clk_en` is low changes nothing.
- R3: `cmd_code[7:6]` selects the operation: 00 loads an A row, 01 loads a B row, 10 reads product row `cmd_code[4:0]`, 11 clears the product. `cmd_code[5]` is ignored.
- R4: The 32 most recent A words form A. The earliest of them is row 0, and bit j of a word is the entry in column j.
- R5: Each accepted B word k (counted from 0 within a group of 32) XORs itself into every product row i for which A[i][k] is 1. After 32 B words, with the product cleared beforehand, the product equals A·B over GF(2).
- R6: On a read, `rsp_data` presents the selected product row in the cycle in which `cmd_done` is high. It holds that value until the next accepted read.
- R7: After a complete group of 32 B words, A is unchanged, and a further group of B words multiplies the same A without any reload.
- R8: The clear command zeroes all product rows. Loading A and reading leave the product unchanged, so multiplies that are not separated by a clear XOR-accumulate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Command qualifier; commands are ignored while low |
| cmd_start | input | 1 | Command request |
| cmd_code | input | 8 | Operation select (bits 7:6) and row index (bits 4:0) |
| cmd_data | input | 32 | Row word for load commands |
| rsp_data | output | 32 | Product row returned by the last read |
| cmd_done | output | 1 | One-cycle completion pulse, one cycle after acceptance |

## Verification
The bound assertions check the handshake on every cycle: a done pulse after every accepted command and none otherwise. They also check that the response word holds between reads, that a clear leaves the whole product at zero, and that loads of A and reads never disturb the product. The arithmetic itself can only be shown by the bench scenarios: identity and all-zero A, random matrices, reuse of A without reloading, accumulation across multiplies, and commands masked by a low `clk_en`. These are compared against a behavioural model and against an independently computed product.

// File: rtl/gf2mm_pkg.sv
package gf2mm_pkg;
  typedef enum logic [1:0] {
    OP_LOAD_A = 2'b00,
    OP_LOAD_B = 2'b01,
    OP_READ   = 2'b10,
    OP_CLEAR  = 2'b11
  } mm_op_e;
endpackage

// File: rtl/gf2mm_cmd_decode.sv
module gf2mm_cmd_decode
  import gf2mm_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int IDX_W  = 5
) (
  input  logic              cmd_start,
  input  logic              clk_en,
  input  logic [CODE_W-1:0] cmd_code,
  output logic              fire_any,
  output logic              fire_a,
  output logic              fire_b,
  output logic              fire_rd,
  output logic              fire_clr,
  output logic [IDX_W-1:0]  row_idx
);
  mm_op_e op;
  logic   unused_code_bits;

  assign op               = mm_op_e'(cmd_code[CODE_W-1 -: 2]);
  assign unused_code_bits = ^cmd_code[CODE_W-3:IDX_W];
  assign fire_any         = cmd_start & clk_en;
  assign row_idx          = cmd_code[IDX_W-1:0];

  always_comb begin
    fire_a   = 1'b0;
    fire_b   = 1'b0;
    fire_rd  = 1'b0;
    fire_clr = 1'b0;
    if (fire_any) begin
      unique case (op)
        OP_LOAD_A: fire_a   = 1'b1;
        OP_LOAD_B: fire_b   = 1'b1;
        OP_READ:   fire_rd  = 1'b1;
        OP_CLEAR:  fire_clr = 1'b1;
        default:   fire_a   = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gf2mm_col_rotator.sv
module gf2mm_col_rotator #(
  parameter int DIM = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_en,
  input  logic [DIM-1:0] load_word,
  input  logic           step_en,
  output logic [DIM-1:0] col_bits
);
  logic [DIM-1:0] rows_q [DIM];

  for (genvar r = 0; r < DIM; r++) begin : g_row
    logic [DIM-1:0] shift_src;
    if (r == DIM-1) begin : g_tail
      assign shift_src = load_word;
    end else begin : g_body
      assign shift_src = rows_q[r+1];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        rows_q[r] <= '0;
      end else if (load_en) begin
        rows_q[r] <= shift_src;
      end else if (step_en) begin
        rows_q[r] <= {rows_q[r][0], rows_q[r][DIM-1:1]};
      end
    end

    assign col_bits[r] = rows_q[r][0];
  end
endmodule

// File: rtl/gf2mm_outer_acc.sv
module gf2mm_outer_acc #(
  parameter int DIM   = 32,
  parameter int IDX_W = $clog2(DIM)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               acc_en,
  input  logic [DIM-1:0]     col_bits,
  input  logic [DIM-1:0]     row_word,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [DIM-1:0]     rd_word,
  output logic [DIM*DIM-1:0] acc_flat
);
  logic [DIM-1:0] acc_q [DIM];

  for (genvar r = 0; r < DIM; r++) begin : g_acc
    logic [DIM-1:0] term;
    assign term = row_word & {DIM{col_bits[r]}};

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        acc_q[r] <= '0;
      end else if (acc_en) begin
        acc_q[r] <= acc_q[r] ^ term;
      end
    end

    assign acc_flat[r*DIM +: DIM] = acc_q[r];
  end

  assign rd_word = acc_q[rd_idx];
endmodule

// File: rtl/gf2_outer_mm.sv
module gf2_outer_mm #(
  parameter int DIM    = 32,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic              cmd_start,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic [DIM-1:0]    cmd_data,
  output logic [DIM-1:0]    rsp_data,
  output logic              cmd_done
);
  localparam int IDX_W = $clog2(DIM);

  logic               fire_any, fire_a, fire_b, fire_rd, fire_clr;
  logic [IDX_W-1:0]   row_idx;
  logic [DIM-1:0]     col_bits;
  logic [DIM-1:0]     rd_word;
  logic [DIM*DIM-1:0] acc_flat;
  logic               done_q;
  logic [DIM-1:0]     rsp_q;

  gf2mm_cmd_decode #(.CODE_W(CODE_W), .IDX_W(IDX_W)) u_dec (
    .cmd_start(cmd_start), .clk_en(clk_en), .cmd_code(cmd_code),
    .fire_any(fire_any), .fire_a(fire_a), .fire_b(fire_b),
    .fire_rd(fire_rd), .fire_clr(fire_clr), .row_idx(row_idx)
  );

  gf2mm_col_rotator #(.DIM(DIM)) u_rot (
    .clk(clk), .rst(rst), .load_en(fire_a), .load_word(cmd_data),
    .step_en(fire_b), .col_bits(col_bits)
  );

  gf2mm_outer_acc #(.DIM(DIM), .IDX_W(IDX_W)) u_acc (
    .clk(clk), .rst(rst), .clr(fire_clr), .acc_en(fire_b),
    .col_bits(col_bits), .row_word(cmd_data), .rd_idx(row_idx),
    .rd_word(rd_word), .acc_flat(acc_flat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      rsp_q  <= '0;
    end else begin
      done_q <= fire_any;
      if (fire_rd) rsp_q <= rd_word;
    end
  end

  assign cmd_done = done_q;
  assign rsp_data = rsp_q;
endmodule

// File: rtl/gf2_outer_mm_chk.sv
module gf2_outer_mm_chk #(
  parameter int DIM    = 32,
  parameter int CODE_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               clk_en,
  input logic               cmd_start,
  input logic [CODE_W-1:0]  cmd_code,
  input logic [DIM-1:0]     rsp_data,
  input logic               cmd_done,
  input logic [DIM*DIM-1:0] acc_flat
);
  logic take;
  logic [1:0] opf;
  assign take = cmd_start && clk_en;
  assign opf  = cmd_code[CODE_W-1 -: 2];

  assert_done_after_take_R2: assert property (@(posedge clk) disable iff (rst)
    take |=> cmd_done);

  assert_no_spurious_done_R2: assert property (@(posedge clk) disable iff (rst)
    !take |=> !cmd_done);

  assert_rsp_holds_R6: assert property (@(posedge clk) disable iff (rst)
    !(take && opf == 2'b10) |=> $stable(rsp_data));

  assert_clear_zeroes_R8: assert property (@(posedge clk) disable iff (rst)
    (take && opf == 2'b11) |=> (acc_flat == '0));

  assert_passive_ops_keep_acc_R8: assert property (@(posedge clk) disable iff (rst)
    (take && (opf == 2'b00 || opf == 2'b10)) |=> $stable(acc_flat));
endmodule

bind gf2_outer_mm gf2_outer_mm_chk #(.DIM(DIM), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .clk_en(clk_en), .cmd_start(cmd_start),
  .cmd_code(cmd_code), .rsp_data(rsp_data), .cmd_done(cmd_done),
  .acc_flat(acc_flat)
);

// File: tb/test_gf2_outer_mm.sv
module test_gf2_outer_mm;
  logic        clk = 1'b0;
  logic        rst;
  logic        clk_en;
  logic        cmd_start;
  logic [7:0]  cmd_code;
  logic [31:0] cmd_data;
  logic [31:0] rsp_data;
  logic        cmd_done;

  int n_chk  = 0;
  int n_fail = 0;

  logic [31:0] m_a   [32];
  logic [31:0] m_acc [32];
  logic [31:0] m_rsp;
  logic        m_done;
  int          m_k;

  logic [31:0] ta [32];
  logic [31:0] tb [32];
  logic [31:0] pr [32];

  always #10 clk = ~clk;

  gf2_outer_mm i_gf2_outer_mm (
    .clk(clk), .rst(rst), .clk_en(clk_en), .cmd_start(cmd_start),
    .cmd_code(cmd_code), .cmd_data(cmd_data), .rsp_data(rsp_data),
    .cmd_done(cmd_done)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) begin
      m_a[i] = '0;
      m_acc[i] = '0;
    end
    m_rsp = '0;
    m_done = 1'b0;
    m_k = 0;
  endtask

  task automatic step(input logic st, input logic ce, input logic [7:0] code,
                      input logic [31:0] d, input string tag);
    cmd_start = st; clk_en = ce; cmd_code = code; cmd_data = d;
    @(posedge clk);
    m_done = st && ce;
    if (st && ce) begin
      case (code[7:6])
        2'b00: begin
          for (int i = 0; i < 31; i++) m_a[i] = m_a[i+1];
          m_a[31] = d;
          m_k = 0;
        end
        2'b01: begin
          for (int i = 0; i < 32; i++) if (m_a[i][m_k]) m_acc[i] ^= d;
          m_k = (m_k + 1) % 32;
        end
        2'b10: m_rsp = m_acc[code[4:0]];
        default: for (int i = 0; i < 32; i++) m_acc[i] = '0;
      endcase
    end
    @(negedge clk);
    cmd_start = 1'b0;
    check(cmd_done == m_done, "R2 done", {31'd0, cmd_done}, {31'd0, m_done});
    check(rsp_data == m_rsp, tag, rsp_data, m_rsp);
  endtask

  task automatic load_a(input string tag);
    for (int i = 0; i < 32; i++) step(1'b1, 1'b1, 8'h00, ta[i], tag);
  endtask

  task automatic load_b(input string tag);
    for (int i = 0; i < 32; i++) step(1'b1, 1'b1, 8'h40, tb[i], tag);
  endtask

  task automatic clear_acc();
    step(1'b1, 1'b1, 8'hC0, 32'hFFFF_FFFF, "R8 clear");
  endtask

  task automatic read_expect(input int idx, input logic [31:0] exp, input string tag);
    step(1'b1, 1'b1, {3'b100, idx[4:0]}, 32'h0, tag);
    check(rsp_data == exp, tag, rsp_data, exp);
  endtask

  function automatic logic [31:0] prod_row(input int i);
    logic [31:0] r = '0;
    for (int k = 0; k < 32; k++) if (ta[i][k]) r ^= tb[k];
    return r;
  endfunction

  task automatic rand_fill(ref logic [31:0] m [32]);
    for (int i = 0; i < 32; i++) m[i] = $urandom;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; clk_en = 1'b0; cmd_start = 1'b0; cmd_code = '0; cmd_data = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(cmd_done == 1'b0, "R1 done", {31'd0, cmd_done}, 32'd0);
    check(rsp_data == 32'd0, "R1 rsp", rsp_data, 32'd0);
    for (int i = 0; i < 32; i++) read_expect(i, 32'd0, "R1 row");

    // R4 R5: identity A gives B back
    for (int i = 0; i < 32; i++) ta[i] = 32'd1 << i;
    rand_fill(tb);
    load_a("R4 load");
    load_b("R5 acc");
    for (int i = 0; i < 32; i++) read_expect(i, tb[i], "R5 identity");

    // R5: zero A gives zero product
    clear_acc();
    for (int i = 0; i < 32; i++) ta[i] = '0;
    rand_fill(tb);
    load_a("R4 load");
    load_b("R5 acc");
    for (int i = 0; i < 32; i++) read_expect(i, 32'd0, "R5 zero");

    // R4 R5: random matrices against independent product
    clear_acc();
    rand_fill(ta);
    rand_fill(tb);
    load_a("R4 load");
    load_b("R5 acc");
    for (int i = 0; i < 32; i++) pr[i] = prod_row(i);
    for (int i = 0; i < 32; i++) read_expect(i, pr[i], "R5 random");

    // R7: reuse A with a new B, no reload
    clear_acc();
    rand_fill(tb);
    load_b("R7 acc");
    for (int i = 0; i < 32; i++) pr[i] = prod_row(i);
    for (int i = 0; i < 32; i++) read_expect(i, pr[i], "R7 reuse");

    // R8: no clear, accumulate a second product
    rand_fill(tb);
    load_b("R8 acc");
    for (int i = 0; i < 32; i++) pr[i] ^= prod_row(i);
    for (int i = 0; i < 32; i++) read_expect(i, pr[i], "R8 accumulate");

    // R8: loading A leaves the product alone
    rand_fill(ta);
    load_a("R8 load");
    for (int i = 0; i < 32; i++) read_expect(i, pr[i], "R8 load keeps acc");

    // R2: commands with clk_en low are ignored
    step(1'b1, 1'b0, 8'hC0, 32'h0, "R2 masked clear");
    step(1'b1, 1'b0, 8'h40, 32'hFFFF_FFFF, "R2 masked B");
    step(1'b1, 1'b0, 8'h83, 32'h0, "R2 masked read");
    read_expect(3, pr[3], "R2 acc unchanged");
    read_expect(17, pr[17], "R2 acc unchanged");

    // R3: bit 5 of the code is ignored on a read
    step(1'b1, 1'b1, 8'hA9, 32'h0, "R3 bit5");
    check(rsp_data == pr[9], "R3 bit5 read", rsp_data, pr[9]);

    // R6: response holds across idle cycles and other commands
    step(1'b0, 1'b1, 8'h80, 32'h0, "R6 hold idle");
    step(1'b0, 1'b1, 8'h80, 32'h0, "R6 hold idle");
    step(1'b1, 1'b1, 8'h00, 32'h1234_5678, "R6 hold load");
    check(rsp_data == pr[9], "R6 hold", rsp_data, pr[9]);

    // R8: clear zeroes every row
    clear_acc();
    for (int i = 0; i < 32; i++) read_expect(i, 32'd0, "R8 cleared");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule